// File: doc/BRIEF.md
# Error-Correcting Dual-Port Memory Wrapper

This block wraps a simple dual-port synchronous RAM with an extended Hamming code. Words enter through one write port and leave through one read port. Every written word is stored together with check bits computed from it. Every word read back is decoded. A single flipped bit anywhere in the stored word is repaired before the data leaves. Two flipped bits are reported as uncorrectable. Both error flags come with the address of the read that raised them.

For bring-up and fault testing, two debug inputs corrupt a word on its way into the RAM. One flips a single bit and the other flips two neighbouring bits. The flip position sits on a rotating pointer that moves on after every corrupted write, so repeated injections reach every bit of the stored word, check bits included. One parameter adds a register stage on the write-side inputs and another adds one on the read-side outputs. The flags and the error address travel with the data through that stage.

Top module: `ecc_ram_wrap`

## Requirements
- R1: The stored word is DATA_W plus K check bits wide. K is 4 for 1–4 data bits, 5 for 5–11, 6 for 12–26, 7 for 27–57 and 8 for 58–64. A write without injection followed by a read returns the written data with `err_single` and `err_double` both low.
- R2: A write with `inj_single` high flips one bit of the encoded word. A later read of that address returns the original data, with `err_single` high and `err_double` low.
- R3: A write with `inj_double` high flips two bits of the encoded word. A later read of that address gives `err_double` high and `err_single` low.
- R4: When `inj_single` and `inj_double` are both high in one write, the double injection is applied. The two error flags are never high together.
- R5: The flip position starts at bit 0 after reset and advances by one after each injected write. Past the top bit of the stored word it wraps to 0. A single injection flips the bit at that position. A double injection flips that bit and the next one, wrapping from the top bit to bit 0.
- R6: The injection inputs have no effect unless `wr_ce` and `wr_we` are both high. The stored word stays unchanged and the flip position does not move.
- R7: `err_addr` presents the address of the read whose result is on `rd_data`, in the same cycle as the data and the flags.
- R8: Read results appear 1 + OUT_REG cycles after the cycle in which `rd_ce` is sampled high. A write takes effect IN_REG cycles after it is presented.
- R9: While reset is asserted and right after it is released, `rd_data`, `err_single`, `err_double` and `err_addr` are zero.
- R10: A read and a write to the same address in the same clock edge returns the word stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_ce | input | 1 | Write port enable |
| wr_we | input | 1 | Write strobe, used together with wr_ce |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| inj_single | input | 1 | Flip one stored bit during this write |
| inj_double | input | 1 | Flip two neighbouring stored bits during this write |
| rd_ce | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Corrected read data |
| err_single | output | 1 | A single-bit error was corrected |
| err_double | output | 1 | An uncorrectable double-bit error was detected |
| err_addr | output | ADDR_W | Address of the read presented on rd_data |

## Verification
Two functions can coincide: a corrupting write and a read of the very same address can land on one clock edge. The bench provokes this by driving an injected write to a word that holds clean data while a read of that address is issued in the same cycle. The read must return the old clean word with both flags low. A later read must then show the corrected new data with the single flag set. The same stimulus is also applied to a second instance with both register stages enabled, where the write lands one cycle later, and it must give the same answers.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int MAX_D = 64;
  localparam int MAX_W = 72;

  // number of check bits (Hamming parity plus one overall parity bit)
  function automatic int chk_bits(input int dw);
    if (dw <= 4)       return 4;
    else if (dw <= 11) return 5;
    else if (dw <= 26) return 6;
    else if (dw <= 57) return 7;
    else               return 8;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v & (v - 1)) == 0;
  endfunction

  // bit 0 holds overall parity, bits 1..n are Hamming positions
  function automatic logic [MAX_W-1:0] ecc_encode(input logic [MAX_D-1:0] d, input int dw);
    logic [MAX_W-1:0] cw;
    logic p;
    int n, j;
    n  = dw + chk_bits(dw) - 1;
    cw = '0;
    j  = 0;
    for (int pos = 1; pos < MAX_W; pos++) begin
      if (pos <= n && !is_pow2(pos)) begin
        cw[pos] = d[j];
        j++;
      end
    end
    for (int b = 0; b < 7; b++) begin
      p = 1'b0;
      for (int pos = 1; pos < MAX_W; pos++)
        if (pos <= n && ((pos >> b) & 1) == 1) p ^= cw[pos];
      if ((1 << b) <= n) cw[1 << b] = p;
    end
    cw[0] = ^cw;
    return cw;
  endfunction

  function automatic logic [6:0] ecc_syndrome(input logic [MAX_W-1:0] cw, input int n);
    logic [6:0] s;
    s = '0;
    for (int pos = 1; pos < MAX_W; pos++)
      if (pos <= n && cw[pos]) s ^= 7'(pos);
    return s;
  endfunction

  function automatic logic [MAX_D-1:0] ecc_extract(input logic [MAX_W-1:0] cw, input int n);
    logic [MAX_D-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int pos = 1; pos < MAX_W; pos++) begin
      if (pos <= n && !is_pow2(pos)) begin
        d[j] = cw[pos];
        j++;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/ecc_inject.sv
module ecc_inject #(
  parameter int CW_W  = 39,
  localparam int POS_W = $clog2(CW_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic             inj_s,
  input  logic             inj_d,
  output logic             fire,
  output logic [POS_W-1:0] pos,
  output logic [CW_W-1:0]  mask
);

  logic [POS_W-1:0] pos_nx;

  assign fire   = wr_go & (inj_s | inj_d);
  assign pos_nx = (pos == POS_W'(CW_W - 1)) ? '0 : pos + 1'b1;

  for (genvar i = 0; i < CW_W; i++) begin : g_mask
    assign mask[i] = fire & ((pos == POS_W'(i)) | (inj_d & (pos_nx == POS_W'(i))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (fire) pos <= pos_nx;
  end

endmodule

// File: rtl/ecc_sdp_ram.sv
module ecc_sdp_ram #(
  parameter int ADDR_W = 4,
  parameter int CW_W   = 39,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [CW_W-1:0]   wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [CW_W-1:0]   rdata
);

  logic [CW_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first: a same-edge write is not yet visible
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ecc_decode.sv
module ecc_decode #(
  parameter int DATA_W = 32,
  parameter int CW_W   = 39
) (
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data,
  output logic              single,
  output logic              double
);
  import ecc_pkg::*;

  localparam int N = CW_W - 1;

  logic [MAX_W-1:0] full, fixed;
  logic [6:0]       syn;
  logic             par_bad;

  always_comb begin
    full    = MAX_W'(cw);
    syn     = ecc_syndrome(full, N);
    par_bad = ^cw;
    single  = par_bad && (int'(syn) <= N);
    double  = (syn != '0 && !par_bad) || (par_bad && int'(syn) > N);
    fixed   = full;
    if (single && syn != '0) fixed[syn] = ~full[syn];
    data    = DATA_W'(ecc_extract(fixed, N));
  end

endmodule

// File: rtl/ecc_ram_wrap.sv
module ecc_ram_wrap #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter bit IN_REG  = 1'b0,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ce,
  input  logic              wr_we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inj_single,
  input  logic              inj_double,
  input  logic              rd_ce,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_single,
  output logic              err_double,
  output logic [ADDR_W-1:0] err_addr
);
  import ecc_pkg::*;

  localparam int CHK_W = chk_bits(DATA_W);
  localparam int CW_W  = DATA_W + CHK_W;
  localparam int POS_W = $clog2(CW_W);

  // write side after the optional input stage
  logic              w_go, w_s, w_d;
  logic [ADDR_W-1:0] w_addr;
  logic [DATA_W-1:0] w_data;

  if (IN_REG) begin : g_in_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_go <= 1'b0; w_s <= 1'b0; w_d <= 1'b0;
        w_addr <= '0; w_data <= '0;
      end else begin
        w_go   <= wr_ce & wr_we;
        w_s    <= inj_single;
        w_d    <= inj_double;
        w_addr <= wr_addr;
        w_data <= wr_data;
      end
    end
  end else begin : g_in_wire
    assign w_go   = wr_ce & wr_we;
    assign w_s    = inj_single;
    assign w_d    = inj_double;
    assign w_addr = wr_addr;
    assign w_data = wr_data;
  end

  // named events for the checker
  logic             inj_fire;
  logic [POS_W-1:0] inj_pos;
  logic [CW_W-1:0]  inj_mask;
  logic [CW_W-1:0]  enc_word;
  logic [MAX_W-1:0] enc_full;

  ecc_inject #(.CW_W(CW_W)) u_inj (
    .clk(clk), .rst_n(rst_n), .wr_go(w_go), .inj_s(w_s), .inj_d(w_d),
    .fire(inj_fire), .pos(inj_pos), .mask(inj_mask)
  );

  assign enc_full = ecc_encode(MAX_D'(w_data), DATA_W);
  assign enc_word = enc_full[CW_W-1:0] ^ inj_mask;

  logic [CW_W-1:0]   ram_q;
  logic [ADDR_W-1:0] raddr_q;

  ecc_sdp_ram #(.ADDR_W(ADDR_W), .CW_W(CW_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(w_go), .waddr(w_addr), .wdata(enc_word),
    .re(rd_ce), .raddr(rd_addr), .rdata(ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     raddr_q <= '0;
    else if (rd_ce) raddr_q <= rd_addr;
  end

  logic [DATA_W-1:0] dec_data;
  logic              dec_s, dec_d;

  ecc_decode #(.DATA_W(DATA_W), .CW_W(CW_W)) u_dec (
    .cw(ram_q), .data(dec_data), .single(dec_s), .double(dec_d)
  );

  if (OUT_REG) begin : g_out_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_data <= '0; err_single <= 1'b0; err_double <= 1'b0; err_addr <= '0;
      end else begin
        rd_data    <= dec_data;
        err_single <= dec_s;
        err_double <= dec_d;
        err_addr   <= raddr_q;
      end
    end
  end else begin : g_out_wire
    assign rd_data    = dec_data;
    assign err_single = dec_s;
    assign err_double = dec_d;
    assign err_addr   = raddr_q;
  end

endmodule

// File: rtl/ecc_ram_wrap_chk.sv
module ecc_ram_wrap_chk #(
  parameter int ADDR_W  = 4,
  parameter int CW_W    = 39,
  parameter bit OUT_REG = 1'b0,
  localparam int POS_W  = $clog2(CW_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_ce,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              err_single,
  input logic              err_double,
  input logic [ADDR_W-1:0] err_addr,
  input logic              w_go,
  input logic              inj_fire,
  input logic [POS_W-1:0]  inj_pos,
  input logic [CW_W-1:0]   inj_mask
);

  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_single && err_double));

  // R5
  pos_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire |=> (inj_pos == (($past(inj_pos) == POS_W'(CW_W - 1)) ? '0 : $past(inj_pos) + 1'b1)));

  // R5
  mask_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire |-> ($countones(inj_mask) == 1 || $countones(inj_mask) == 2));

  // R6
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_fire |=> $stable(inj_pos));

  // R6
  no_mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !w_go |-> (inj_mask == '0));

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!err_single && !err_double && err_addr == '0);
    end
  end

  if (OUT_REG) begin : g_lat2
    // R7
    err_addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_ce, 2) |-> (err_addr == $past(rd_addr, 2)));
  end else begin : g_lat1
    // R7
    err_addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_ce) |-> (err_addr == $past(rd_addr)));
  end

endmodule

bind ecc_ram_wrap ecc_ram_wrap_chk #(
  .ADDR_W(ADDR_W), .CW_W(CW_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_ce(rd_ce), .rd_addr(rd_addr),
  .err_single(err_single), .err_double(err_double), .err_addr(err_addr),
  .w_go(w_go), .inj_fire(inj_fire), .inj_pos(inj_pos), .inj_mask(inj_mask)
);

// File: tb/tb_ecc_ram_wrap.sv
module tb_ecc_ram_wrap;
  localparam int PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;

  // stored width restated: smallest h with 2^h >= DW+h+1, plus overall parity
  function automatic int stored_width(input int dw);
    int h;
    h = 1;
    while ((1 << h) < dw + h + 1) h++;
    return dw + h + 1;
  endfunction
  localparam int SW = stored_width(DW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_ce = 0, wr_we = 0, inj_s = 0, inj_d = 0, rd_ce = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;

  logic [DW-1:0] a_data, b_data;
  logic a_s, a_d, b_s, b_d;
  logic [AW-1:0] a_addr, b_addr;

  always #(PERIOD/2) clk = ~clk;

  ecc_ram_wrap #(.DATA_W(DW), .ADDR_W(AW), .IN_REG(1'b0), .OUT_REG(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_ce(wr_ce), .wr_we(wr_we), .wr_addr(wr_addr),
    .wr_data(wr_data), .inj_single(inj_s), .inj_double(inj_d), .rd_ce(rd_ce),
    .rd_addr(rd_addr), .rd_data(a_data), .err_single(a_s), .err_double(a_d),
    .err_addr(a_addr));

  ecc_ram_wrap #(.DATA_W(DW), .ADDR_W(AW), .IN_REG(1'b1), .OUT_REG(1'b1)) dut_p (
    .clk(clk), .rst_n(rst_n), .wr_ce(wr_ce), .wr_we(wr_we), .wr_addr(wr_addr),
    .wr_data(wr_data), .inj_single(inj_s), .inj_double(inj_d), .rd_ce(rd_ce),
    .rd_addr(rd_addr), .rd_data(b_data), .err_single(b_s), .err_double(b_d),
    .err_addr(b_addr));

  int checks = 0, errors = 0, rot = 0;
  bit done = 0;
  int exp_f [16];          // 0 clean, 1 single, 2 double
  logic [DW-1:0] exp_d [16];

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]    inj;     // bit0 single, bit1 double
    logic [1:0]    flag;    // expected flag class
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{4'd0, 32'h0000_0000, 2'd0, 2'd0},
    '{4'd1, 32'hFFFF_FFFF, 2'd0, 2'd0},
    '{4'd2, 32'hA5A5_5A5A, 2'd1, 2'd1},
    '{4'd3, 32'h1234_5678, 2'd2, 2'd2},
    '{4'd4, 32'h8000_0001, 2'd3, 2'd2},
    '{4'd5, 32'h0F0F_F0F0, 2'd1, 2'd1},
    '{4'd6, 32'hDEAD_BEEF, 2'd1, 2'd1},
    '{4'd7, 32'h7FFF_FFFE, 2'd2, 2'd2}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic note_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic s, input logic dd);
    exp_d[a] = d;
    exp_f[a] = dd ? 2 : (s ? 1 : 0);
    if (s || dd) rot = (rot + 1) % SW;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic s, input logic dd);
    @(negedge clk);
    wr_ce = 1; wr_we = 1; wr_addr = a; wr_data = d; inj_s = s; inj_d = dd;
    @(negedge clk);
    wr_ce = 0; wr_we = 0; inj_s = 0; inj_d = 0;
    note_write(a, d, s, dd);
    @(negedge clk);
  endtask

  task automatic check_out(input string req, input logic [DW-1:0] d, input logic s, input logic dd,
                           input logic [AW-1:0] ad, input int f, input logic [AW-1:0] a);
    chk({req, " single"}, 64'(s), 64'(f == 1));
    chk({req, " double"}, 64'(dd), 64'(f == 2));
    chk({req, " addr R7"}, 64'(ad), 64'(a));
    if (f != 2) chk({req, " data"}, 64'(d), 64'(exp_d[a]));
  endtask

  task automatic do_read(input string req, input logic [AW-1:0] a);
    logic [DW-1:0] prev_b;
    @(negedge clk);
    prev_b = b_data;
    rd_ce = 1; rd_addr = a;
    @(negedge clk);
    rd_ce = 0;
    check_out({req, " fast"}, a_data, a_s, a_d, a_addr, exp_f[a], a);
    chk("R8 piped not yet", 64'(b_data), 64'(prev_b));
    @(negedge clk);
    check_out({req, " piped R8"}, b_data, b_s, b_d, b_addr, exp_f[a], a);
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin exp_f[i] = 0; exp_d[i] = '0; end
    repeat (3) @(negedge clk);
    // R9: outputs quiet in reset
    chk("R9 data in reset", 64'(a_data), 64'h0);
    chk("R9 flags in reset", 64'({a_s, a_d, b_s, b_d}), 64'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 after release", 64'({a_data, a_addr, b_addr}), 64'h0);

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < 8; i++)
      do_write(VEC[i].addr, VEC[i].data, VEC[i].inj[0], VEC[i].inj[1]);
    for (int i = 0; i < 8; i++) begin
      chk("R1 R4 table class", 64'(exp_f[VEC[i].addr]), 64'(VEC[i].flag));
      do_read($sformatf("R1/R2/R3/R4 vec%0d", i), VEC[i].addr);
    end

    // R10: injected write and read of same address on one edge
    @(negedge clk);
    wr_ce = 1; wr_we = 1; wr_addr = 4'd0; wr_data = 32'hC0DE_0001; inj_s = 1;
    rd_ce = 1; rd_addr = 4'd0;
    @(negedge clk);
    wr_ce = 0; wr_we = 0; inj_s = 0; rd_ce = 0;
    check_out("R10 fast", a_data, a_s, a_d, a_addr, 0, 4'd0);
    @(negedge clk);
    check_out("R10 piped", b_data, b_s, b_d, b_addr, 0, 4'd0);
    note_write(4'd0, 32'hC0DE_0001, 1'b1, 1'b0);
    @(negedge clk);
    do_read("R10 R2 after", 4'd0);

    // R6: injection without a full write strobe
    do_write(4'd8, 32'h5555_AAAA, 1'b0, 1'b0);
    @(negedge clk);
    wr_ce = 1; wr_we = 0; wr_addr = 4'd8; wr_data = 32'h0; inj_d = 1;
    @(negedge clk);
    wr_ce = 0; wr_we = 1; inj_s = 1;
    @(negedge clk);
    wr_we = 0; inj_s = 0; inj_d = 0;
    @(negedge clk);
    do_read("R6 ignored", 4'd8);

    // R5: walk the flip position to the top bit, then wrap with a double
    while (rot != SW - 1) begin
      do_write(4'd9, 32'h3C3C_0000 ^ 32'(rot), 1'b1, 1'b0);
      do_read("R5 walk", 4'd9);
    end
    do_write(4'd9, 32'h0BAD_F00D, 1'b0, 1'b1);
    do_read("R5 wrap double", 4'd9);
    chk("R5 pointer wrapped", 64'(rot), 64'h0);
    do_write(4'd9, 32'h600D_F00D, 1'b1, 1'b0);
    do_read("R5 bit0 single", 4'd9);

    // R1: clean overwrite clears an error
    do_write(4'd3, 32'h2468_ACE0, 1'b0, 1'b0);
    do_read("R1 overwrite", 4'd3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule